// File: doc/BRIEF.md
# Clock Source Changeover Sequencer

This block moves a processor clock off its PLL-derived path and onto the crystal reference while the PLL is being retuned, then moves it back once the PLL is stable again. It drives two select bits. The output select chooses between the crystal and the divided path. The source select chooses whether the divider chain is fed from the crystal or from the PLL. It does not touch the PLL, the divider settings or any register bus. It only orders the two mux moves and times the settling gaps between them.

A requester presents one event per handshake on `evt_valid` with a two-bit `evt_kind`. A park event (`2'b01`) parks the output on the crystal. The block then waits a settling interval and after that points the source at the PLL. A resume event (`2'b10`) returns the output to the divided path and then waits a second settling interval. The remaining codes (`2'b00`, `2'b11`) are acknowledged and change neither mux. The settling interval is a cycle count computed from the reference clock frequency and the desired settling time in microseconds. `busy` covers each sequence, and a one-cycle `done` pulse closes it.

Top module: `clk_changeover_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_sel` (0 = crystal, 1 = divided path), `src_sel` (0 = crystal, 1 = PLL), `busy` and `done` are all 0.
- R2: A park event (`evt_kind` = 2'b01) accepted at a clock edge sets `out_sel` to 0 and `busy` to 1 after that same edge. `src_sel` is left unchanged at that point.
- R3: During a park sequence, `src_sel` keeps its value until exactly SETTLE_CYCLES edges after the accepting edge. At that edge it becomes 1, and `done` rises and `busy` falls together with it.
- R4: A resume event (`evt_kind` = 2'b10) accepted at a clock edge sets `out_sel` to 1 and `busy` to 1 after that edge, and it leaves `src_sel` unchanged.
- R5: A resume sequence signals completion (`done` = 1, `busy` = 0) exactly SETTLE_CYCLES edges after its accepting edge. `out_sel` holds 1 for the whole wait.
- R6: An event with `evt_kind` 2'b00 or 2'b11 accepted while idle changes neither mux and never raises `busy`. It produces a `done` pulse after the accepting edge.
- R7: `busy` is 1 from the accepting edge of a park or resume event until the edge that raises `done` for that sequence, and it is 0 otherwise.
- R8: Events presented while `busy` is 1 are ignored. This includes the edge at which the sequence completes. Ignored events affect neither mux nor the completion time.
- R9: `done` is high for exactly one cycle per accepted event.
- R10: A resume event is carried out even when no park event preceded it since reset.
- R11: SETTLE_CYCLES equals ceil(REF_CLK_KHZ × SETTLE_US / 1000), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_kind | input | 2 | Event code: 01 park, 10 resume, 00/11 other |
| out_sel | output | 1 | Output mux select: 0 crystal, 1 divided path |
| src_sel | output | 1 | Source mux select: 0 crystal, 1 PLL |
| busy | output | 1 | A park or resume sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with REF_CLK_KHZ = 120 and SETTLE_US = 100, which gives a settling count of 12 cycles. With that count the bench can check every cycle of both waits individually: it confirms that the source select holds until the twelfth edge and that completion lands on exactly that edge. The short count also leaves room for several sequences in a row, for events injected in the middle of a wait and on the completion edge, and for a resume issued straight after reset.

// File: rtl/clkswap_pkg.sv
package clkswap_pkg;

  typedef enum logic [1:0] {
    KIND_OTHER0 = 2'b00,
    KIND_PARK   = 2'b01,
    KIND_RESUME = 2'b10,
    KIND_OTHER1 = 2'b11
  } evt_kind_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_PARK,
    ACT_RESUME,
    ACT_ACK
  } action_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PARK_WAIT,
    ST_RESUME_WAIT
  } seq_state_e;

  function automatic int settle_count(input int ref_khz, input int usec);
    int raw;
    raw = (ref_khz * usec + 999) / 1000;
    return (raw < 1) ? 1 : raw;
  endfunction

endpackage

// File: rtl/clkswap_evt_decode.sv
module clkswap_evt_decode
  import clkswap_pkg::*;
#(
  parameter int KIND_W = 2
) (
  input  logic              evt_valid,
  input  logic [KIND_W-1:0] evt_kind,
  input  logic              accept_en,
  output action_e           action
);

  always_comb begin
    action = ACT_NONE;
    if (evt_valid && accept_en) begin
      unique case (evt_kind)
        KIND_PARK:   action = ACT_PARK;
        KIND_RESUME: action = ACT_RESUME;
        default:     action = ACT_ACK;
      endcase
    end
  end

endmodule

// File: rtl/clkswap_settle_timer.sv
module clkswap_settle_timer #(
  parameter int CYCLES = 12,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic last
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (start) begin
      remain_q <= CNT_W'(CYCLES);
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  // high in the cycle whose closing edge is the CYCLES-th edge after start
  assign last = (remain_q == CNT_W'(1));

endmodule

// File: rtl/clkswap_fsm.sv
module clkswap_fsm
  import clkswap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  action_e action,
  input  logic    settle_last,
  output logic    timer_start,
  output logic    accept_en,
  output logic    out_sel,
  output logic    src_sel,
  output logic    busy,
  output logic    done
);

  seq_state_e state_q;

  assign accept_en   = (state_q == ST_IDLE);
  assign timer_start = (action == ACT_PARK) || (action == ACT_RESUME);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      out_sel <= 1'b0;
      src_sel <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          unique case (action)
            ACT_PARK: begin
              out_sel <= 1'b0;
              busy    <= 1'b1;
              state_q <= ST_PARK_WAIT;
            end
            ACT_RESUME: begin
              out_sel <= 1'b1;
              busy    <= 1'b1;
              state_q <= ST_RESUME_WAIT;
            end
            ACT_ACK: begin
              done <= 1'b1;
            end
            default: ;
          endcase
        end
        ST_PARK_WAIT: begin
          if (settle_last) begin
            src_sel <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_RESUME_WAIT: begin
          if (settle_last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clk_changeover_seq.sv
module clk_changeover_seq
  import clkswap_pkg::*;
#(
  parameter int REF_CLK_KHZ = 24000,
  parameter int SETTLE_US   = 100,
  parameter int KIND_W      = 2,
  localparam int SETTLE_CYCLES = settle_count(REF_CLK_KHZ, SETTLE_US)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [KIND_W-1:0] evt_kind,
  output logic              out_sel,
  output logic              src_sel,
  output logic              busy,
  output logic              done
);

  action_e action;
  logic    accept_en;
  logic    timer_start;
  logic    settle_last;

  clkswap_evt_decode #(.KIND_W(KIND_W)) u_decode (
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .accept_en (accept_en),
    .action    (action)
  );

  clkswap_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (timer_start),
    .last  (settle_last)
  );

  clkswap_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .action      (action),
    .settle_last (settle_last),
    .timer_start (timer_start),
    .accept_en   (accept_en),
    .out_sel     (out_sel),
    .src_sel     (src_sel),
    .busy        (busy),
    .done        (done)
  );

endmodule

// File: rtl/clk_changeover_seq_chk.sv
module clk_changeover_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       evt_valid,
  input logic [1:0] evt_kind,
  input logic       out_sel,
  input logic       src_sel,
  input logic       busy,
  input logic       done
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_sel && !src_sel && !busy && !done));

  // R2
  park_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && evt_valid && evt_kind == 2'b01) |=> (!out_sel && busy && $stable(src_sel)));

  // R4
  resume_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && evt_valid && evt_kind == 2'b10) |=> (out_sel && busy && $stable(src_sel)));

  // R6
  other_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && evt_valid && (evt_kind == 2'b00 || evt_kind == 2'b11))
      |=> (done && !busy && $stable(out_sel) && $stable(src_sel)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R3
  src_switch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(src_sel) |-> (done && $fell(busy) && !out_sel));

endmodule

bind clk_changeover_seq clk_changeover_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_valid (evt_valid),
  .evt_kind  (evt_kind),
  .out_sel   (out_sel),
  .src_sel   (src_sel),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_clk_changeover_seq.sv
`timescale 1ns/1ps
module test_clk_changeover_seq;

  localparam int REF_KHZ = 120;
  localparam int SET_US  = 100;
  localparam int N       = (REF_KHZ * SET_US + 999) / 1000; // R11: 12

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_valid = 1'b0;
  logic [1:0] evt_kind = 2'b00;
  logic       out_sel, src_sel, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  clk_changeover_seq #(.REF_CLK_KHZ(REF_KHZ), .SETTLE_US(SET_US)) i_clk_changeover_seq (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .out_sel(out_sel), .src_sel(src_sel), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] k);
    evt_valid = 1'b1;
    evt_kind  = k;
    step();
    evt_valid = 1'b0;
    evt_kind  = 2'b00;
  endtask

  task automatic t_reset();
    check("R1", "out_sel", out_sel, 0);
    check("R1", "src_sel", src_sel, 0);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
  endtask

  task automatic t_park(input bit inject);
    int src0 = src_sel;
    issue(2'b01);
    check("R2", "out_sel after park", out_sel, 0);
    check("R2", "src_sel held", src_sel, src0);
    check("R7", "busy raised", busy, 1);
    for (int i = 1; i < N; i++) begin
      if (inject && (i == 3 || i == N - 1)) begin
        evt_valid = 1'b1;
        evt_kind  = 2'b10;
      end
      step();
      evt_valid = 1'b0;
      check("R3", "src_sel during wait", src_sel, src0);
      check("R7", "busy during wait", busy, 1);
      check("R9", "no early done", done, 0);
      if (inject) check("R8", "out_sel ignores resume", out_sel, 0);
    end
    if (inject) begin
      evt_valid = 1'b1;
      evt_kind  = 2'b10;
    end
    step();
    evt_valid = 1'b0;
    check("R3", "src_sel switched", src_sel, 1);
    check("R3", "done at end", done, 1);
    check("R7", "busy dropped", busy, 0);
    check("R3", "out_sel still crystal", out_sel, 0);
    step();
    check("R9", "done single cycle", done, 0);
    if (inject) begin
      check("R8", "ignored resume not run", out_sel, 0);
      check("R8", "not busy after ignore", busy, 0);
    end
  endtask

  task automatic t_resume(input string tag);
    int src0 = src_sel;
    issue(2'b10);
    check("R4", "out_sel after resume", out_sel, 1);
    check("R4", "src_sel held", src_sel, src0);
    check(tag, "busy raised", busy, 1);
    for (int i = 1; i < N; i++) begin
      step();
      check("R5", "busy during wait", busy, 1);
      check("R5", "no early done", done, 0);
      check("R5", "out_sel held", out_sel, 1);
    end
    step();
    check("R5", "done at end", done, 1);
    check("R5", "busy dropped", busy, 0);
    check(tag, "src_sel unchanged", src_sel, src0);
    step();
    check("R9", "done single cycle", done, 0);
  endtask

  task automatic t_other(input logic [1:0] k);
    int o0 = out_sel;
    int s0 = src_sel;
    issue(k);
    check("R6", "done pulse", done, 1);
    check("R6", "busy low", busy, 0);
    check("R6", "out_sel unchanged", out_sel, o0);
    check("R6", "src_sel unchanged", src_sel, s0);
    step();
    check("R9", "done single cycle", done, 0);
    check("R6", "out_sel still unchanged", out_sel, o0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    step();
    step();
    rst = 1'b0;
    step();
    t_reset();
    t_resume("R10");
    t_park(1'b0);
    t_resume("R7");
    t_other(2'b00);
    t_other(2'b11);
    t_park(1'b1);
    t_resume("R7");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule